// File: doc/BRIEF.md
# Call Stack and Status Word Unit

This unit keeps the status byte of a small 8-bit microcontroller and runs its subroutine return stack, which lives in on-chip byte-addressed RAM. The control path raises one of five requests: a call, a plain return, a status-restoring return, a status-byte write, or a flag update. The unit answers with a program-counter load and drives a single-port RAM. The status byte is always readable on `psw_out`.

A call packs the four upper flags into bits 15:12 of the 16-bit return word. The low 12 bits of that word hold the next-instruction address. The unit then writes the word into RAM one byte per cycle and loads the PC with the call target. A return reads the word back. A plain return discards the packed flags. A status-restoring return copies them back into the flag bits. Each push or pop occupies the RAM for two byte cycles, and `busy` shows when the unit cannot take a new request.

Top module: `callstack_psw_unit`

## Requirements
- R1: While reset is asserted and after it is released, all four flags are 0, the stack level is 0, `psw_out` reads 8'h08 and `busy` is low.
- R2: `psw_out` is {C, AC, F0, BS, 1'b1, level[2:0]}, with C in bit 7, BS in bit 4 and the level in bits 2:0. The stack pointer is 8 + 2*level.
- R3: A status-byte write taken while idle loads C, AC, F0 and BS from data bits 7:4 and the level from bits 2:0. Bit 3 is ignored. The next push then lands at RAM address 8 + 2*level.
- R4: A call writes the word {C, AC, F0, BS, next_pc[11:0]} in two consecutive cycles. The low byte goes to SP in the first cycle and the high byte to SP+1 in the second. The flag values are those held before the call is taken. The level then increases by 1.
- R5: In the second write cycle of a call, `pc_load` pulses for one cycle and `pc_value` is {tgt_bank, tgt_page[2:0], tgt_low[7:0]}, that is, bank*2048 + page*256 + low.
- R6: A plain return first lowers the level by 1. It then reads SP and SP+1 in two consecutive cycles. In the cycle after the second read, it pulses `pc_load` with the low 12 bits of the word read. The flags are left unchanged.
- R7: A status-restoring return behaves like R6 and in addition loads C, AC, F0 and BS from bits 15:12 of the word read.
- R8: The level wraps modulo 8, so the stack addresses stay within 8..23. A push at level 7 writes 22 and 23, a ninth nested push overwrites addresses 8 and 9, and a pop at level 0 reads 22 and 23. No overflow or underflow is signalled.
- R9: `busy` is high from the cycle after a call or return is taken until its last cycle. Requests presented while `busy` is high are ignored.
- R10: When several requests are presented together while idle, call wins over plain return, plain return wins over status-restoring return, and status-restoring return wins over status write. Only the winner takes effect.
- R11: A flag update presented together with a call that is being taken changes the flags, but the pushed word carries the flags from before the update.
- R12: In the final cycle of a status-restoring return, the restored flags win over a flag update. A status-byte write that is taken wins over a flag update in the same cycle. At all other times a flag update takes effect at the next edge.
- R13: The RAM read data is taken one cycle after `ram_re` is raised for that address. `ram_we` and `ram_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_req | input | 1 | Call request |
| ret_req | input | 1 | Plain return request |
| retr_req | input | 1 | Status-restoring return request |
| psw_wr_req | input | 1 | Status-byte write request |
| psw_wr_data | input | 8 | Status byte to write |
| flag_wr | input | 1 | Flag update strobe from the control path |
| flag_c | input | 1 | New carry |
| flag_ac | input | 1 | New auxiliary carry |
| flag_f0 | input | 1 | New user flag F0 |
| flag_bs | input | 1 | New register-bank select |
| next_pc | input | 12 | Address of the next instruction |
| tgt_bank | input | 1 | Memory-bank bit of the call target |
| tgt_page | input | 3 | Page field of the call target |
| tgt_low | input | 8 | Operand byte of the call target |
| ram_rdata | input | 8 | RAM read data, valid one cycle after ram_re |
| busy | output | 1 | A push or pop is in progress |
| ram_addr | output | 8 | RAM byte address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_wdata | output | 8 | RAM write data |
| pc_load | output | 1 | Program-counter load pulse |
| pc_value | output | 12 | Program-counter load value |
| psw_out | output | 8 | Current status byte |

## Verification
A flag update from the control path can fall in the same cycle as a call being taken, as a status-byte write, or as the final cycle of a status-restoring return. The bench provokes each case by holding `flag_wr` with a chosen flag pattern across those cycles. It judges the result from the bytes that reach the RAM port and from `psw_out` afterwards. A behavioural model that applies the R11/R12 priorities compares the outputs every cycle, and a second set of tests presents requests together, or while `busy` is high, to exercise R9 and R10.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int PC_W    = 12;
  localparam int FLAG_N  = 4;
  localparam int WORD_W  = PC_W + FLAG_N;
  localparam int BYTE_W  = 8;
  localparam int LEVEL_W = 3;
  localparam int PAGE_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_POP_LO,
    ST_POP_HI,
    ST_POP_DONE
  } seq_st_t;
endpackage

// File: rtl/cs_level_ptr.sv
module cs_level_ptr
  import cs_pkg::*;
#(
  parameter int STACK_BASE = 8,
  parameter int ADDR_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  input  logic               dec,
  input  logic               load,
  input  logic [LEVEL_W-1:0] load_val,
  output logic [LEVEL_W-1:0] level,
  output logic [ADDR_W-1:0]  base_addr
);
  logic [LEVEL_W-1:0] level_q, level_d;
  logic               level_en;

  // wraps modulo 2**LEVEL_W by width
  always_comb begin
    level_en = inc | dec | load;
    level_d  = level_q;
    if (load)     level_d = load_val;
    else if (dec) level_d = level_q - 1'b1;
    else if (inc) level_d = level_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level_q <= '0;
    else if (level_en) level_q <= level_d;
  end

  assign level     = level_q;
  assign base_addr = ADDR_W'(STACK_BASE) + ADDR_W'({level_q, 1'b0});
endmodule

// File: rtl/cs_flag_reg.sv
module cs_flag_reg
  import cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restore,
  input  logic [FLAG_N-1:0] restore_val,
  input  logic              load,
  input  logic [FLAG_N-1:0] load_val,
  input  logic              upd,
  input  logic [FLAG_N-1:0] upd_val,
  output logic [FLAG_N-1:0] flags
);
  logic [FLAG_N-1:0] flags_q, flags_d;
  logic              flags_en;

  // priority: restore from stack, then status write, then control-path update
  always_comb begin
    flags_en = restore | load | upd;
    if (restore)   flags_d = restore_val;
    else if (load) flags_d = load_val;
    else           flags_d = upd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/cs_seq.sv
module cs_seq
  import cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_go,
  input  logic              pop_go,
  input  logic              pop_restore,
  input  logic [WORD_W-1:0] word_in,
  input  logic [PC_W-1:0]   target_in,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              busy,
  output logic              ram_we,
  output logic              ram_re,
  output logic              byte_sel,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_value,
  output logic              push_done,
  output logic              restore,
  output logic [FLAG_N-1:0] restore_flags
);
  seq_st_t           state_q, state_d;
  logic [WORD_W-1:0] word_q;
  logic [PC_W-1:0]   tgt_q;
  logic [BYTE_W-1:0] lo_q;
  logic              mode_q;
  logic              word_en, lo_en, mode_en;

  always_comb begin
    state_d = state_q;
    word_en = 1'b0;
    lo_en   = 1'b0;
    mode_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (call_go) begin
          state_d = ST_PUSH_LO;
          word_en = 1'b1;
        end else if (pop_go) begin
          state_d = ST_POP_LO;
          mode_en = 1'b1;
        end
      end
      ST_PUSH_LO:  state_d = ST_PUSH_HI;
      ST_PUSH_HI:  state_d = ST_IDLE;
      ST_POP_LO:   state_d = ST_POP_HI;
      ST_POP_HI: begin
        state_d = ST_POP_DONE;
        lo_en   = 1'b1;
      end
      ST_POP_DONE: state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      tgt_q   <= '0;
      lo_q    <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (word_en) begin
        word_q <= word_in;
        tgt_q  <= target_in;
      end
      if (lo_en)   lo_q   <= ram_rdata;
      if (mode_en) mode_q <= pop_restore;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign ram_we        = (state_q == ST_PUSH_LO) || (state_q == ST_PUSH_HI);
  assign ram_re        = (state_q == ST_POP_LO) || (state_q == ST_POP_HI);
  assign byte_sel      = (state_q == ST_PUSH_HI) || (state_q == ST_POP_HI);
  assign ram_wdata     = byte_sel ? word_q[WORD_W-1 -: BYTE_W] : word_q[BYTE_W-1:0];
  assign push_done     = (state_q == ST_PUSH_HI);
  assign pc_load       = push_done || (state_q == ST_POP_DONE);
  assign pc_value      = push_done ? tgt_q : {ram_rdata[PC_W-BYTE_W-1:0], lo_q};
  assign restore       = (state_q == ST_POP_DONE) && mode_q;
  assign restore_flags = ram_rdata[BYTE_W-1 -: FLAG_N];
endmodule

// File: rtl/callstack_psw_unit.sv
module callstack_psw_unit
  import cs_pkg::*;
#(
  parameter int STACK_BASE = 8,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic              retr_req,
  input  logic              psw_wr_req,
  input  logic [7:0]        psw_wr_data,
  input  logic              flag_wr,
  input  logic              flag_c,
  input  logic              flag_ac,
  input  logic              flag_f0,
  input  logic              flag_bs,
  input  logic [PC_W-1:0]   next_pc,
  input  logic              tgt_bank,
  input  logic [PAGE_W-1:0] tgt_page,
  input  logic [7:0]        tgt_low,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic              ram_re,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_value,
  output logic [7:0]        psw_out
);
  logic [1:0]         rst_sync_q;
  logic               rst_q;
  logic               acc_call, acc_pop, acc_psw, pop_restore;
  logic               push_done, restore, byte_sel;
  logic [FLAG_N-1:0]  flags, restore_flags;
  logic [LEVEL_W-1:0] level;
  logic [ADDR_W-1:0]  base_addr;
  logic               unused_psw_bit3;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  assign acc_call    = !busy && call_req;
  assign acc_pop     = !busy && !call_req && (ret_req || retr_req);
  assign pop_restore = !ret_req;
  assign acc_psw     = !busy && !call_req && !ret_req && !retr_req && psw_wr_req;
  assign unused_psw_bit3 = psw_wr_data[3];

  cs_level_ptr #(.STACK_BASE(STACK_BASE), .ADDR_W(ADDR_W)) u_level (
    .clk       (clk),
    .rst_n     (rst_q),
    .inc       (push_done),
    .dec       (acc_pop),
    .load      (acc_psw),
    .load_val  (psw_wr_data[LEVEL_W-1:0]),
    .level     (level),
    .base_addr (base_addr)
  );

  cs_flag_reg u_flags (
    .clk         (clk),
    .rst_n       (rst_q),
    .restore     (restore),
    .restore_val (restore_flags),
    .load        (acc_psw),
    .load_val    (psw_wr_data[7 -: FLAG_N]),
    .upd         (flag_wr),
    .upd_val     ({flag_c, flag_ac, flag_f0, flag_bs}),
    .flags       (flags)
  );

  cs_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_q),
    .call_go       (acc_call),
    .pop_go        (acc_pop),
    .pop_restore   (pop_restore),
    .word_in       ({flags, next_pc}),
    .target_in     ({tgt_bank, tgt_page, tgt_low}),
    .ram_rdata     (ram_rdata),
    .busy          (busy),
    .ram_we        (ram_we),
    .ram_re        (ram_re),
    .byte_sel      (byte_sel),
    .ram_wdata     (ram_wdata),
    .pc_load       (pc_load),
    .pc_value      (pc_value),
    .push_done     (push_done),
    .restore       (restore),
    .restore_flags (restore_flags)
  );

  assign ram_addr = base_addr + ADDR_W'(byte_sel);
  assign psw_out  = {flags, 1'b1, level};
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
  parameter int STACK_BASE = 8,
  parameter int ADDR_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_req,
  input logic              ret_req,
  input logic              retr_req,
  input logic              psw_wr_req,
  input logic [7:0]        psw_wr_data,
  input logic              busy,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_we,
  input logic              ram_re,
  input logic              pc_load,
  input logic [7:0]        psw_out
);
  localparam int TOP_ADDR = STACK_BASE + 16;

  assert_psw_bit3_R2: assert property (@(posedge clk) disable iff (!rst_n)
    psw_out[3] == 1'b1);

  assert_active_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re || pc_load) |-> busy);

  assert_call_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !busy) |=> busy);

  assert_push_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !$past(ram_we)) |=> (ram_we && ram_addr == $past(ram_addr) + 1'b1));

  assert_addr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> (int'(ram_addr) >= STACK_BASE && int'(ram_addr) < TOP_ADDR));

  assert_psw_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_wr_req && !busy && !call_req && !ret_req && !retr_req) |=>
      (psw_out == {$past(psw_wr_data[7:4]), 1'b1, $past(psw_wr_data[2:0])}));

  assert_we_re_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ram_we, ram_re}) <= 1);
endmodule

bind callstack_psw_unit cs_checker #(.STACK_BASE(STACK_BASE), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .call_req    (call_req),
  .ret_req     (ret_req),
  .retr_req    (retr_req),
  .psw_wr_req  (psw_wr_req),
  .psw_wr_data (psw_wr_data),
  .busy        (busy),
  .ram_addr    (ram_addr),
  .ram_we      (ram_we),
  .ram_re      (ram_re),
  .pc_load     (pc_load),
  .psw_out     (psw_out)
);

// File: tb/sim_callstack_psw_unit.sv
`timescale 1ns/1ps
module sim_callstack_psw_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, call_req, ret_req, retr_req, psw_wr_req, flag_wr;
  logic        flag_c, flag_ac, flag_f0, flag_bs, tgt_bank;
  logic [7:0]  psw_wr_data, tgt_low, ram_rdata, ram_addr, ram_wdata, psw_out;
  logic [2:0]  tgt_page;
  logic [11:0] next_pc, pc_value;
  logic        busy, ram_we, ram_re, pc_load;

  callstack_psw_unit u0 (.*);

  // environment RAM: one-cycle read latency
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: op 0 idle, 1 call, 2 ret, 3 retr
  int          m_op, m_ph, m_lvl;
  logic [3:0]  m_fl;
  logic [15:0] m_word;
  logic [11:0] m_tgt;
  logic [15:0] stk [8];
  bit          m_take;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_op = 0; m_ph = 0; m_lvl = 0; m_fl = 4'h0; m_word = 16'h0; m_tgt = 12'h0;
    end else begin
      m_take = flag_wr;
      case (m_op)
        0: if (call_req) begin
             m_word = {m_fl, next_pc}; m_tgt = {tgt_bank, tgt_page, tgt_low};
             m_op = 1; m_ph = 0;
           end else if (ret_req || retr_req) begin
             m_lvl = (m_lvl + 7) % 8; m_op = ret_req ? 2 : 3; m_ph = 0;
           end else if (psw_wr_req) begin
             m_fl = psw_wr_data[7:4]; m_lvl = int'(psw_wr_data[2:0]); m_take = 0;
           end
        1: if (m_ph == 0) m_ph = 1;
           else begin stk[m_lvl] = m_word; m_lvl = (m_lvl + 1) % 8; m_op = 0; end
        default:
           if (m_ph < 2) m_ph++;
           else begin
             if (m_op == 3) begin m_fl = stk[m_lvl][15:12]; m_take = 0; end
             m_op = 0;
           end
      endcase
      if (m_take) m_fl = {flag_c, flag_ac, flag_f0, flag_bs};
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic int  e_addr = 8 + 2 * m_lvl + m_ph;
      automatic bit  e_we   = (m_op == 1);
      automatic bit  e_re   = (m_op >= 2) && (m_ph < 2);
      automatic bit  e_pcl  = (m_op == 1 && m_ph == 1) || (m_op >= 2 && m_ph == 2);
      chk("R2 psw_out", 16'(psw_out), 16'({m_fl, 1'b1, 3'(m_lvl)}));
      chk("R9 busy", 16'(busy), 16'(m_op != 0));
      chk("R4 ram_we", 16'(ram_we), 16'(e_we));
      chk("R13 ram_re", 16'(ram_re), 16'(e_re));
      chk("R5 pc_load", 16'(pc_load), 16'(e_pcl));
      if (e_we) begin
        chk("R4 ram_addr", 16'(ram_addr), 16'(e_addr));
        chk("R4 ram_wdata", 16'(ram_wdata), 16'(m_ph == 1 ? m_word[15:8] : m_word[7:0]));
      end
      if (e_re) chk("R6 ram_addr", 16'(ram_addr), 16'(e_addr));
      if (e_pcl) begin
        if (m_op == 1) chk("R5 pc_value", 16'(pc_value), 16'(m_tgt));
        else           chk("R6 pc_value", 16'(pc_value), 16'(stk[m_lvl][11:0]));
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic clear_reqs();
    call_req = 0; ret_req = 0; retr_req = 0; psw_wr_req = 0; flag_wr = 0;
  endtask

  task automatic finish_op();
    step(); clear_reqs();
    while (busy) step();
  endtask

  task automatic set_flags(logic [3:0] f);
    {flag_c, flag_ac, flag_f0, flag_bs} = f;
  endtask

  task automatic do_call(logic [11:0] pc, logic b, logic [2:0] pg, logic [7:0] lo);
    next_pc = pc; tgt_bank = b; tgt_page = pg; tgt_low = lo; call_req = 1;
    finish_op();
  endtask

  task automatic do_psw(logic [7:0] d);
    psw_wr_data = d; psw_wr_req = 1; finish_op();
  endtask

  task automatic do_flags(logic [3:0] f);
    set_flags(f); flag_wr = 1; finish_op();
  endtask

  task automatic summary();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) stk[i] = 16'h0;
    rst_n = 0; clear_reqs(); set_flags(4'h0);
    psw_wr_data = 0; next_pc = 0; tgt_bank = 0; tgt_page = 0; tgt_low = 0;
    repeat (3) step();
    chk("R1 psw in reset", 16'(psw_out), 16'h0008);
    chk("R1 busy in reset", 16'(busy), 16'h0);
    rst_n = 1;
    repeat (4) step();
    chk("R1 psw after reset", 16'(psw_out), 16'h0008);

    // R4/R5: call with flags C,F0 set
    do_flags(4'b1010);
    chk("R2 flags", 16'(psw_out), 16'h00A8);
    do_call(12'h123, 1'b1, 3'd5, 8'h4C);
    chk("R4 word in RAM", {mem[9], mem[8]}, 16'hA123);
    chk("R4 level up", 16'(psw_out), 16'h00A9);

    // R6: plain return keeps current flags
    do_flags(4'b0000);
    ret_req = 1; finish_op();
    chk("R6 flags kept", 16'(psw_out), 16'h0008);

    // R7: status-restoring return
    do_flags(4'b0101);
    do_call(12'h456, 1'b0, 3'd2, 8'h10);
    do_flags(4'b0000);
    retr_req = 1; finish_op();
    chk("R7 flags restored", 16'(psw_out), 16'h0058);

    // R3: status write, bit 3 ignored, next push at 8+2*5
    do_psw(8'hF5);
    chk("R3 psw loaded", 16'(psw_out), 16'h00FD);
    do_call(12'h789, 1'b0, 3'd7, 8'hFF);
    chk("R3 push address", {mem[19], mem[18]}, 16'hF789);

    // R8: wrap at level 7 and back
    do_psw(8'h07);
    do_call(12'h0AB, 1'b1, 3'd0, 8'h01);
    chk("R8 push at top", {mem[23], mem[22]}, 16'h00AB);
    chk("R8 level wrapped to 0", 16'(psw_out), 16'h0008);
    ret_req = 1; finish_op();
    chk("R8 pop wrapped to 7", 16'(psw_out), 16'h000F);

    // R8: nine nested calls overwrite the first slot
    do_psw(8'h00);
    for (int i = 0; i < 9; i++) do_call(12'(i + 12'h300), 1'b0, 3'(i), 8'(i));
    chk("R8 ninth push overwrote slot 0", {mem[9], mem[8]}, 16'h0308);
    chk("R8 level after nine", 16'(psw_out), 16'h0009);
    ret_req = 1; finish_op();
    retr_req = 1; finish_op();

    // R9: requests while busy are ignored
    do_psw(8'h02);
    next_pc = 12'h5A5; call_req = 1;
    step(); call_req = 0; ret_req = 1; psw_wr_data = 8'hF0; psw_wr_req = 1;
    step(); clear_reqs();
    while (busy) step();
    chk("R9 busy requests ignored", 16'(psw_out), 16'h000B);

    // R10: simultaneous requests
    next_pc = 12'h111; call_req = 1; ret_req = 1; psw_wr_data = 8'hF7; psw_wr_req = 1;
    finish_op();
    chk("R10 call wins", 16'(psw_out), 16'h000C);
    do_flags(4'b1100);
    do_call(12'h222, 1'b0, 3'd1, 8'h22);
    do_flags(4'b0000);
    ret_req = 1; retr_req = 1; finish_op();
    chk("R10 ret wins over retr", 16'(psw_out), 16'h000C);
    retr_req = 1; psw_wr_data = 8'hF1; psw_wr_req = 1; finish_op();
    chk("R10 retr wins over psw write", 16'(psw_out), 16'h000B);

    // R11: flag update in the call cycle
    do_psw(8'h00);
    set_flags(4'b1111); flag_wr = 1; next_pc = 12'hABC; call_req = 1;
    finish_op();
    chk("R11 pushed old flags", {mem[9], mem[8]}, 16'h0ABC);
    chk("R11 flags updated", 16'(psw_out), 16'h00F9);

    // R12: flag update held through a restoring return, and against psw write
    do_flags(4'b0110);
    do_call(12'h333, 1'b1, 3'd3, 8'h33);
    set_flags(4'b1111); flag_wr = 1; retr_req = 1;
    step(); retr_req = 0;
    while (busy) step();
    flag_wr = 0;
    chk("R12 restore beats update", 16'(psw_out), 16'h0069);
    set_flags(4'b1111); flag_wr = 1; psw_wr_data = 8'h23; psw_wr_req = 1;
    finish_op();
    chk("R12 psw write beats update", 16'(psw_out), 16'h002B);
    do_flags(4'b1001);
    chk("R12 plain update", 16'(psw_out), 16'h009B);

    repeat (3) step();
    summary();
  end
endmodule